// File: doc/BRIEF.md
# FASTQ Record Splitter and Checker

This block takes a byte-wide ASCII stream of FASTQ records and separates each record into its three parts. The identifier, base sequence and quality lines each go out on their own valid-qualified byte stream. The separator line, line terminators and carriage returns never reach any output. Each output stream marks the final character of its part, so a downstream compressor can find record boundaries without counting.

While the first record's identifier line is parsed, the block learns a template: the identifier's length, its characters, and the position and character of every byte that is neither a digit nor a letter. A downstream identifier encoder reads this template through two index-addressed read ports once `tmpl_valid` is high. Every record is then checked against the template and against itself. Four sticky flags report a bad base, a quality/base length mismatch, a changed delimiter structure and a missing record part. Parsing carries on after any flag is raised.

Top module: `fq_record_splitter`

## Requirements
- R1: Identifier-line bytes (including the leading `@`) appear on the id stream, sequence-line bytes on the seq stream and quality-line bytes on the qual stream, each in input order. The separator line, newline (0x0A) and carriage-return (0x0D) bytes appear on no stream. At most one stream is valid in any cycle.
- R2: Each forwarded line's final character carries its stream's last bit, and no other character does. The last-marked byte comes out in the cycle after the newline that ends the line is accepted.
- R3: A forwarded character is output in the cycle after the next non-CR byte of the input (the following character or the newline) is accepted. In a cycle after an idle input or a CR byte, no stream is valid.
- R4: When the first record's identifier line ends, `tmpl_valid` rises. At that point `tmpl_len` holds its byte count, `tmpl_char[i]` holds character i, `tmpl_spec_cnt` holds the number of non-alphanumeric characters, and special-table entry k holds the position and character of the k-th of them (up to 16 entries). The template never changes afterwards.
- R5: flags[0] is set when a sequence line contains a byte other than uppercase A, C, G, T or N. That byte is still forwarded.
- R6: flags[1] is set at the end of a quality line whose character count differs from the record's base count. The base count restarts at each identifier line, so a missing sequence counts as zero bases.
- R7: flags[2] is set at the end of any later identifier line whose count of non-alphanumeric characters differs from the template's. It is also set if, for any of the first 16 such characters, the k-th one differs from the template's k-th one. Positions are not compared.
- R8: flags[3] is set in four cases: an empty line, an identifier line not starting with `@`, a separator line not starting with `+`, or a sequence line starting with `+` (the sequence is missing and that line is treated as the separator).
- R9: Flags stay set until `flag_clr` is sampled high. A flag being set in the same cycle as a clear ends up set.
- R10: After reset, no stream is valid, `flags` is 0 and `tmpl_valid` is 0.
- R11: An identifier line lacking `@` is dropped and the next line is again taken as an identifier. A wrong separator line is dropped and the next line is taken as quality. A complete record following either is split and checked normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte qualifier |
| in_byte | input | 8 | ASCII input byte |
| flag_clr | input | 1 | Synchronous clear of all flags |
| id_valid | output | 1 | Identifier stream byte valid |
| id_byte | output | 8 | Identifier stream byte |
| id_last | output | 1 | Final identifier byte of the record |
| seq_valid | output | 1 | Sequence stream byte valid |
| seq_byte | output | 8 | Sequence stream byte |
| seq_last | output | 1 | Final base of the record |
| qual_valid | output | 1 | Quality stream byte valid |
| qual_byte | output | 8 | Quality stream byte |
| qual_last | output | 1 | Final quality byte of the record |
| tmpl_valid | output | 1 | Template captured |
| tmpl_len | output | 8 | Template identifier length in bytes |
| tmpl_spec_cnt | output | 8 | Template count of non-alphanumeric characters |
| tmpl_char_sel | input | log2(ID_MAX) | Template character index |
| tmpl_char | output | 8 | Template character at tmpl_char_sel |
| tmpl_spec_sel | input | log2(SPEC_MAX) | Special-table entry index |
| tmpl_spec_pos | output | 8 | Position of the selected special character |
| tmpl_spec_kind | output | 8 | The selected special character |
| flags | output | 4 | Sticky flags: bit0 base, bit1 length, bit2 delimiter, bit3 missing part |

## Verification
The splitting path is exercised in three ways:
- Well-formed records with random identifier field values, random sequence lengths over all five base letters and random quality characters, some with CR-LF endings. These show that routing, last marking and CR removal hold, and that no flag rises on clean data.
- Directed malformed records, each built to trip exactly one condition: a foreign base, a short quality line, a changed delimiter, a missing separator, a missing sequence, an unmarked identifier and an empty line. These tell apart the four flags and the resynchronisation rules.
- Byte-by-byte probes with idle gaps, and a clear that lands on the same byte as a flag event. These pin down the one-byte hold latency and the clear-versus-set priority.

// File: rtl/fq_split_pkg.sv
package fq_split_pkg;

    localparam logic [7:0] CH_LF   = 8'h0A;
    localparam logic [7:0] CH_CR   = 8'h0D;
    localparam logic [7:0] CH_AT   = 8'h40;
    localparam logic [7:0] CH_PLUS = 8'h2B;

    localparam int NSTREAM   = 3;
    localparam int NFLAG     = 4;
    localparam int FLAG_BASE = 0;
    localparam int FLAG_LEN  = 1;
    localparam int FLAG_SPEC = 2;
    localparam int FLAG_MISS = 3;

    // Which line of the record is being parsed or expected next.
    typedef enum logic [1:0] {
        PART_ID   = 2'd0,
        PART_SEQ  = 2'd1,
        PART_PLUS = 2'd2,
        PART_QUAL = 2'd3
    } part_e;

    // Destination of a character; value minus one indexes the stream.
    typedef enum logic [1:0] {
        ROLE_NONE = 2'd0,
        ROLE_ID   = 2'd1,
        ROLE_SEQ  = 2'd2,
        ROLE_QUAL = 2'd3
    } role_e;

    // One parse event per accepted input byte.
    typedef struct packed {
        logic       ch;    // forwarded character
        logic       eol;   // end of a line
        role_e      role;  // stream of the character or of the ended line
        logic [7:0] data;
        logic       miss;  // structural defect seen on this byte
    } evt_t;

    function automatic logic is_alnum(input logic [7:0] c);
        return (c >= 8'h30 && c <= 8'h39) ||
               (c >= 8'h41 && c <= 8'h5A) ||
               (c >= 8'h61 && c <= 8'h7A);
    endfunction

    function automatic logic is_base(input logic [7:0] c);
        return (c == 8'h41) || (c == 8'h43) || (c == 8'h47) ||
               (c == 8'h54) || (c == 8'h4E);
    endfunction

    function automatic part_e next_part(input part_e p);
        case (p)
            PART_ID:   return PART_SEQ;
            PART_SEQ:  return PART_PLUS;
            PART_PLUS: return PART_QUAL;
            default:   return PART_ID;
        endcase
    endfunction

    function automatic role_e role_of(input part_e p);
        case (p)
            PART_ID:   return ROLE_ID;
            PART_SEQ:  return ROLE_SEQ;
            PART_QUAL: return ROLE_QUAL;
            default:   return ROLE_NONE;
        endcase
    endfunction

    function automatic logic [7:0] sat_inc8(input logic [7:0] v);
        return (v == 8'hFF) ? v : v + 8'd1;
    endfunction

endpackage

// File: rtl/fq_line_tracker.sv
module fq_line_tracker
    import fq_split_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output evt_t       evt
);

    part_e part_q, part_d;
    logic  mid_q, mid_d;    // inside a non-empty line
    logic  skip_q, skip_d;  // current line is not forwarded
    logic  take;

    assign take = in_valid && (in_byte != CH_CR);

    always_comb begin
        evt      = '0;
        evt.data = in_byte;
        part_d   = part_q;
        mid_d    = mid_q;
        skip_d   = skip_q;
        if (take) begin
            if (in_byte == CH_LF) begin
                evt.eol = 1'b1;
                mid_d   = 1'b0;
                skip_d  = 1'b0;
                if (!mid_q) begin
                    evt.miss = 1'b1;
                    part_d   = (part_q == PART_ID) ? PART_ID : next_part(part_q);
                end else begin
                    evt.role = skip_q ? ROLE_NONE : role_of(part_q);
                    part_d   = (part_q == PART_ID && skip_q) ? PART_ID : next_part(part_q);
                end
            end else if (!mid_q) begin
                mid_d = 1'b1;
                case (part_q)
                    PART_ID: begin
                        if (in_byte == CH_AT) begin
                            evt.ch   = 1'b1;
                            evt.role = ROLE_ID;
                        end else begin
                            evt.miss = 1'b1;
                            skip_d   = 1'b1;
                        end
                    end
                    PART_SEQ: begin
                        if (in_byte == CH_PLUS) begin
                            evt.miss = 1'b1;
                            skip_d   = 1'b1;
                            part_d   = PART_PLUS;
                        end else begin
                            evt.ch   = 1'b1;
                            evt.role = ROLE_SEQ;
                        end
                    end
                    PART_PLUS: begin
                        skip_d   = 1'b1;
                        evt.miss = (in_byte != CH_PLUS);
                    end
                    default: begin
                        evt.ch   = 1'b1;
                        evt.role = ROLE_QUAL;
                    end
                endcase
            end else if (!skip_q) begin
                evt.ch   = 1'b1;
                evt.role = role_of(part_q);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q <= PART_ID;
            mid_q  <= 1'b0;
            skip_q <= 1'b0;
        end else begin
            part_q <= part_d;
            mid_q  <= mid_d;
            skip_q <= skip_d;
        end
    end

endmodule

// File: rtl/fq_out_stage.sv
module fq_out_stage
    import fq_split_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  evt_t                    evt,
    output logic [NSTREAM-1:0]      o_valid,
    output logic [NSTREAM-1:0][7:0] o_data,
    output logic [NSTREAM-1:0]      o_last
);

    logic       pend_v;
    role_e      pend_role;
    logic [7:0] pend_data;
    logic       new_ch;
    logic       emit;

    assign new_ch = evt.ch && (evt.role != ROLE_NONE);
    assign emit   = pend_v && (new_ch || evt.eol);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_role <= ROLE_NONE;
            pend_data <= '0;
        end else if (new_ch) begin
            pend_v    <= 1'b1;
            pend_role <= evt.role;
            pend_data <= evt.data;
        end else if (evt.eol) begin
            pend_v    <= 1'b0;
        end
    end

    for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
        logic hit;
        assign hit = emit && (pend_role == role_e'(2'(s + 1)));
        always_ff @(posedge clk) begin
            if (rst) begin
                o_valid[s] <= 1'b0;
                o_data[s]  <= '0;
                o_last[s]  <= 1'b0;
            end else begin
                o_valid[s] <= hit;
                if (hit) begin
                    o_data[s] <= pend_data;
                    o_last[s] <= evt.eol;
                end
            end
        end
    end

endmodule

// File: rtl/fq_id_template.sv
module fq_id_template
    import fq_split_pkg::*;
#(
    parameter int ID_MAX   = 64,
    parameter int SPEC_MAX = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  evt_t                        evt,
    input  logic [$clog2(ID_MAX)-1:0]   char_sel,
    input  logic [$clog2(SPEC_MAX)-1:0] spec_sel,
    output logic                        tmpl_valid,
    output logic [7:0]                  tmpl_len,
    output logic [7:0]                  tmpl_spec_cnt,
    output logic [7:0]                  tmpl_char,
    output logic [7:0]                  spec_pos,
    output logic [7:0]                  spec_kind,
    output logic                        spec_err
);

    localparam int ID_IW = $clog2(ID_MAX);
    localparam int SP_IW = $clog2(SPEC_MAX);

    logic [7:0] chars_q [ID_MAX];
    logic [7:0] spos_q  [SPEC_MAX];
    logic [7:0] skind_q [SPEC_MAX];
    logic       valid_q;
    logic [7:0] tlen_q, tcnt_q;
    logic [7:0] pos_q, cnt_q;
    logic       mism_q;

    logic id_ch, id_eol, special, pos_in, cnt_in;
    logic [SP_IW-1:0] sidx;

    assign id_ch   = evt.ch  && (evt.role == ROLE_ID);
    assign id_eol  = evt.eol && (evt.role == ROLE_ID);
    assign special = !is_alnum(evt.data);
    assign pos_in  = int'(pos_q) < ID_MAX;
    assign cnt_in  = int'(cnt_q) < SPEC_MAX;
    assign sidx    = cnt_q[SP_IW-1:0];

    assign spec_err = id_eol && valid_q && (mism_q || (cnt_q != tcnt_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            tlen_q  <= '0;
            tcnt_q  <= '0;
            pos_q   <= '0;
            cnt_q   <= '0;
            mism_q  <= 1'b0;
            for (int i = 0; i < ID_MAX; i++) chars_q[i] <= '0;
            for (int k = 0; k < SPEC_MAX; k++) begin
                spos_q[k]  <= '0;
                skind_q[k] <= '0;
            end
        end else begin
            if (id_ch) begin
                pos_q <= sat_inc8(pos_q);
                if (special) cnt_q <= sat_inc8(cnt_q);
                if (!valid_q) begin
                    if (pos_in) chars_q[pos_q[ID_IW-1:0]] <= evt.data;
                    if (special && cnt_in) begin
                        spos_q[sidx]  <= pos_q;
                        skind_q[sidx] <= evt.data;
                    end
                end else if (special && cnt_in && (evt.data != skind_q[sidx])) begin
                    mism_q <= 1'b1;
                end
            end
            if (id_eol) begin
                pos_q  <= '0;
                cnt_q  <= '0;
                mism_q <= 1'b0;
                if (!valid_q) begin
                    valid_q <= 1'b1;
                    tlen_q  <= pos_q;
                    tcnt_q  <= cnt_q;
                end
            end
        end
    end

    assign tmpl_valid    = valid_q;
    assign tmpl_len      = tlen_q;
    assign tmpl_spec_cnt = tcnt_q;
    assign tmpl_char     = chars_q[char_sel];
    assign spec_pos      = spos_q[spec_sel];
    assign spec_kind     = skind_q[spec_sel];

endmodule

// File: rtl/fq_record_check.sv
module fq_record_check
    import fq_split_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  evt_t             evt,
    input  logic             spec_err,
    input  logic             flag_clr,
    output logic [NFLAG-1:0] flags
);

    logic [CNT_W-1:0] bases_q, qcnt_q;
    logic [NFLAG-1:0] flags_q, set;

    always_comb begin
        set            = '0;
        set[FLAG_BASE] = evt.ch && (evt.role == ROLE_SEQ) && !is_base(evt.data);
        set[FLAG_LEN]  = evt.eol && (evt.role == ROLE_QUAL) && (qcnt_q != bases_q);
        set[FLAG_SPEC] = spec_err;
        set[FLAG_MISS] = evt.miss;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bases_q <= '0;
            qcnt_q  <= '0;
            flags_q <= '0;
        end else begin
            flags_q <= (flag_clr ? '0 : flags_q) | set;
            if (evt.eol && evt.role == ROLE_ID)
                bases_q <= '0;
            else if (evt.ch && evt.role == ROLE_SEQ && bases_q != '1)
                bases_q <= bases_q + 1'b1;
            if (evt.eol && evt.role == ROLE_QUAL)
                qcnt_q <= '0;
            else if (evt.ch && evt.role == ROLE_QUAL && qcnt_q != '1)
                qcnt_q <= qcnt_q + 1'b1;
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/fq_record_splitter.sv
module fq_record_splitter
    import fq_split_pkg::*;
#(
    parameter int ID_MAX   = 64,
    parameter int SPEC_MAX = 16,
    parameter int CNT_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [7:0]                  in_byte,
    input  logic                        flag_clr,
    output logic                        id_valid,
    output logic [7:0]                  id_byte,
    output logic                        id_last,
    output logic                        seq_valid,
    output logic [7:0]                  seq_byte,
    output logic                        seq_last,
    output logic                        qual_valid,
    output logic [7:0]                  qual_byte,
    output logic                        qual_last,
    output logic                        tmpl_valid,
    output logic [7:0]                  tmpl_len,
    output logic [7:0]                  tmpl_spec_cnt,
    input  logic [$clog2(ID_MAX)-1:0]   tmpl_char_sel,
    output logic [7:0]                  tmpl_char,
    input  logic [$clog2(SPEC_MAX)-1:0] tmpl_spec_sel,
    output logic [7:0]                  tmpl_spec_pos,
    output logic [7:0]                  tmpl_spec_kind,
    output logic [3:0]                  flags
);

    evt_t                    evt;
    logic                    spec_err;
    logic [NSTREAM-1:0]      o_valid;
    logic [NSTREAM-1:0][7:0] o_data;
    logic [NSTREAM-1:0]      o_last;

    fq_line_tracker u_track (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .evt      (evt)
    );

    fq_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .o_valid (o_valid),
        .o_data  (o_data),
        .o_last  (o_last)
    );

    fq_id_template #(
        .ID_MAX   (ID_MAX),
        .SPEC_MAX (SPEC_MAX)
    ) u_tmpl (
        .clk           (clk),
        .rst           (rst),
        .evt           (evt),
        .char_sel      (tmpl_char_sel),
        .spec_sel      (tmpl_spec_sel),
        .tmpl_valid    (tmpl_valid),
        .tmpl_len      (tmpl_len),
        .tmpl_spec_cnt (tmpl_spec_cnt),
        .tmpl_char     (tmpl_char),
        .spec_pos      (tmpl_spec_pos),
        .spec_kind     (tmpl_spec_kind),
        .spec_err      (spec_err)
    );

    fq_record_check #(
        .CNT_W (CNT_W)
    ) u_chk_flags (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .spec_err (spec_err),
        .flag_clr (flag_clr),
        .flags    (flags)
    );

    assign id_valid   = o_valid[0];
    assign id_byte    = o_data[0];
    assign id_last    = o_last[0];
    assign seq_valid  = o_valid[1];
    assign seq_byte   = o_data[1];
    assign seq_last   = o_last[1];
    assign qual_valid = o_valid[2];
    assign qual_byte  = o_data[2];
    assign qual_last  = o_last[2];

endmodule

// File: rtl/fq_splitter_chk.sv
module fq_splitter_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       flag_clr,
    input logic       id_valid,
    input logic       seq_valid,
    input logic       qual_valid,
    input logic       id_last,
    input logic       seq_last,
    input logic       qual_last,
    input logic       tmpl_valid,
    input logic [7:0] tmpl_len,
    input logic [7:0] tmpl_spec_cnt,
    input logic [3:0] flags
);

    AST_ONE_STREAM: assert property (@(posedge clk) disable iff (rst)
        $onehot0({id_valid, seq_valid, qual_valid})); // R1

    AST_QUIET_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || in_byte == 8'h0D) |=> !(id_valid || seq_valid || qual_valid)); // R3

    AST_LAST_AFTER_LF: assert property (@(posedge clk) disable iff (rst)
        ((id_valid && id_last) || (seq_valid && seq_last) || (qual_valid && qual_last))
        |-> $past(in_valid && in_byte == 8'h0A)); // R2

    AST_MID_AFTER_CHAR: assert property (@(posedge clk) disable iff (rst)
        ((id_valid && !id_last) || (seq_valid && !seq_last) || (qual_valid && !qual_last))
        |-> $past(in_valid && in_byte != 8'h0A && in_byte != 8'h0D)); // R3

    AST_TMPL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        tmpl_valid |=> tmpl_valid && $stable(tmpl_len) && $stable(tmpl_spec_cnt)); // R4

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !flag_clr |=> ((flags & $past(flags)) == $past(flags))); // R9

    AST_CLR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !in_valid) |=> (flags == 4'b0000)); // R9

endmodule

bind fq_record_splitter fq_splitter_chk u_assert_chk (.*);

// File: tb/tb_fq_record_splitter.sv
module tb_fq_record_splitter;

    localparam int CLK_PERIOD = 10;
    localparam int ID_MAX     = 64;
    localparam int SPEC_MAX   = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       flag_clr = 1'b0;
    logic       id_valid, seq_valid, qual_valid;
    logic [7:0] id_byte, seq_byte, qual_byte;
    logic       id_last, seq_last, qual_last;
    logic       tmpl_valid;
    logic [7:0] tmpl_len, tmpl_spec_cnt, tmpl_char, tmpl_spec_pos, tmpl_spec_kind;
    logic [5:0] tmpl_char_sel = '0;
    logic [3:0] tmpl_spec_sel = '0;
    logic [3:0] flags;

    int n_chk = 0;
    int n_err = 0;

    logic [8:0] exp_id[$], exp_seq[$], exp_qual[$];
    logic [8:0] got_id[$], got_seq[$], got_qual[$];

    fq_record_splitter #(.ID_MAX(ID_MAX), .SPEC_MAX(SPEC_MAX)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            if (id_valid)   got_id.push_back({id_last, id_byte});
            if (seq_valid)  got_seq.push_back({seq_last, seq_byte});
            if (qual_valid) got_qual.push_back({qual_last, qual_byte});
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit alnum(input byte c);
        return (c >= "0" && c <= "9") || (c >= "A" && c <= "Z") || (c >= "a" && c <= "z");
    endfunction

    function automatic int spec_count(input string s);
        int n = 0;
        for (int i = 0; i < s.len(); i++) if (!alnum(s[i])) n++;
        return n;
    endfunction

    task automatic send_byte(input byte b, input bit clr = 1'b0);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        flag_clr = clr;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            flag_clr = 1'b0;
        end
    endtask

    task automatic push_exp(input int dest, input logic [8:0] v);
        case (dest)
            1: exp_id.push_back(v);
            2: exp_seq.push_back(v);
            3: exp_qual.push_back(v);
            default: ;
        endcase
    endtask

    // dest: 0 not forwarded, 1 id, 2 seq, 3 qual
    task automatic send_line(input string s, input int dest, input bit crlf = 1'b0);
        for (int i = 0; i < s.len(); i++) begin
            send_byte(s[i]);
            push_exp(dest, {(i == s.len() - 1), s[i]});
        end
        if (crlf) send_byte(8'h0D);
        send_byte(8'h0A);
    endtask

    task automatic send_rec(input string id, input string sq, input string pl,
                            input string ql, input bit crlf = 1'b0);
        send_line(id, 1, crlf);
        send_line(sq, 2, crlf);
        send_line(pl, 0, crlf);
        send_line(ql, 3, crlf);
    endtask

    function automatic int first_diff(input logic [8:0] e[$], input logic [8:0] g[$]);
        int n = (e.size() > g.size()) ? e.size() : g.size();
        for (int i = 0; i < n; i++)
            if (i >= e.size() || i >= g.size() || e[i] !== g[i]) return i;
        return -1;
    endfunction

    task automatic cmp_one(input string req, input string nm,
                           input logic [8:0] e[$], input logic [8:0] g[$]);
        int d = first_diff(e, g);
        int av = (d >= 0 && d < g.size()) ? int'(g[d]) : -1;
        int ev = (d >= 0 && d < e.size()) ? int'(e[d]) : -1;
        check(d < 0, req, {nm, " stream item"}, av, ev);
    endtask

    task automatic cmp_streams(input string req);
        cmp_one(req, "id", exp_id, got_id);
        cmp_one(req, "seq", exp_seq, got_seq);
        cmp_one(req, "qual", exp_qual, got_qual);
        exp_id.delete(); exp_seq.delete(); exp_qual.delete();
        got_id.delete(); got_seq.delete(); got_qual.delete();
    endtask

    task automatic clear_flags();
        @(negedge clk);
        in_valid = 1'b0;
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic expect_flags(input string req, input logic [3:0] e);
        idle(3);
        check(flags === e, req, "flags", int'(flags), int'(e));
    endtask

    function automatic string rand_id();
        return $sformatf("@SIM%0d:%0d:FC%0d %0d/%0d", $urandom % 1000, $urandom % 100,
                         $urandom % 50, 1 + $urandom % 9, 1 + $urandom % 2);
    endfunction

    function automatic string rand_seq(input int n);
        string s = "";
        string al = "ACGTN";
        for (int i = 0; i < n; i++) s = $sformatf("%s%c", s, al[$urandom % 5]);
        return s;
    endfunction

    function automatic string rand_qual(input int n);
        string s = "";
        for (int i = 0; i < n; i++) s = $sformatf("%s%c", s, 8'(33 + $urandom % 41));
        return s;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        string tid;
        string id;
        string sq;
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10 reset state
        check(flags === 4'b0 && !tmpl_valid && !id_valid && !seq_valid && !qual_valid,
              "R10", "reset state", {flags, tmpl_valid}, 0);
        rst = 1'b0;
        idle(2);

        // R4 template capture from the first record
        tid = "@SIM7:42:FC1 1/2";
        send_rec(tid, "ACGTN", "+", "IIIII");
        idle(3);
        check(tmpl_valid === 1'b1, "R4", "tmpl_valid", tmpl_valid, 1);
        check(tmpl_len == 8'(tid.len()), "R4", "tmpl_len", tmpl_len, tid.len());
        check(tmpl_spec_cnt == 8'(spec_count(tid)), "R4", "tmpl_spec_cnt",
              tmpl_spec_cnt, spec_count(tid));
        n = 0;
        for (int i = 0; i < tid.len(); i++) begin
            tmpl_char_sel = 6'(i);
            #1;
            check(tmpl_char == tid[i], "R4", $sformatf("tmpl_char[%0d]", i), tmpl_char, tid[i]);
            if (!alnum(tid[i])) begin
                tmpl_spec_sel = 4'(n);
                #1;
                check(tmpl_spec_pos == 8'(i) && tmpl_spec_kind == tid[i], "R4",
                      $sformatf("special entry %0d", n), {tmpl_spec_pos, tmpl_spec_kind},
                      {8'(i), tid[i]});
                n++;
            end
        end
        cmp_streams("R1 R2 first record");
        check(flags === 4'b0, "R5 R6 R7 R8", "flags after clean record", flags, 0);

        // Random clean records, some CR-LF, some with a repeated identifier on the separator
        for (int r = 0; r < 60; r++) begin
            id = rand_id();
            n  = 1 + $urandom % 40;
            sq = rand_seq(n);
            send_rec(id, sq, ($urandom % 2) ? "+" : {"+", id.substr(1, id.len() - 1)},
                     rand_qual(n), ($urandom % 2) == 1);
        end
        idle(4);
        cmp_streams("R1 R2 random records");
        check(flags === 4'b0, "R7", "flags after random clean records", flags, 0);
        check(tmpl_len == 8'(tid.len()), "R4", "tmpl_len unchanged", tmpl_len, tid.len());

        // R3 one-byte hold: '@' emerges when 'Q' is taken, 'Q' waits for the newline
        clear_flags();
        send_byte("@");
        send_byte("Q");
        idle(3);
        check(got_id.size() == 1, "R3", "id bytes before newline", got_id.size(), 1);
        send_byte(8'h0A);
        idle(2);
        check(got_id.size() == 2 && got_id[1] == {1'b1, 8'h51}, "R3", "last id byte after LF",
              (got_id.size() == 2) ? int'(got_id[1]) : -1, 9'h151);
        exp_id.push_back({1'b0, 8'h40});
        exp_id.push_back({1'b1, 8'h51});
        send_line("A", 2);
        send_line("+", 0);
        send_line("I", 3);
        expect_flags("R7 lone @", 4'b0100);
        cmp_streams("R1 R3");

        // R5 foreign base, still forwarded
        clear_flags();
        send_rec("@SIM3:1:FC2 5/1", "ACGXT", "+", "IIIII");
        expect_flags("R5", 4'b0001);
        // R9 sticky across a clean record
        send_rec("@SIM4:1:FC2 5/1", "GGA", "+", "III", 1'b1);
        expect_flags("R9 sticky", 4'b0001);
        cmp_streams("R1 R5");

        // R6 short quality
        clear_flags();
        check(flags === 4'b0, "R9", "cleared flags", flags, 0);
        send_rec("@SIM5:2:FC9 2/2", "ACGT", "+", "III");
        expect_flags("R6", 4'b0010);

        // R7 changed delimiter kind and extra delimiter
        clear_flags();
        send_rec("@SIM5:2:FC9_2/2", "ACGT", "+", "IIII");
        expect_flags("R7 kind", 4'b0100);
        clear_flags();
        send_rec("@SIM5:2:FC9 2/2:7", "ACGT", "+", "IIII");
        expect_flags("R7 count", 4'b0100);
        cmp_streams("R1 R7");

        // R8 wrong separator line, R11 next line taken as quality
        clear_flags();
        send_line("@SIM6:3:FC1 1/1", 1);
        send_line("ACGT", 2);
        send_line("JJJJ", 0);
        send_line("IIII", 3);
        expect_flags("R8 R11 separator", 4'b1000);
        cmp_streams("R11 separator resync");

        // R8 missing sequence; R6 compares against zero bases
        clear_flags();
        send_line("@SIM6:3:FC1 1/1", 1);
        send_line("+", 0);
        send_line("IIII", 3);
        expect_flags("R8 R6 missing sequence", 4'b1010);

        // R8 identifier without '@', R11 following record parsed
        clear_flags();
        send_line("XYZ", 0);
        send_rec("@SIM8:8:FC8 8/1", "TTN", "+", "III");
        expect_flags("R8 R11 bad id", 4'b1000);
        cmp_streams("R11 id resync");

        // R8 empty line in identifier position
        clear_flags();
        send_byte(8'h0A);
        send_rec("@SIM8:9:FC8 8/1", "CA", "+", "II");
        expect_flags("R8 empty line", 4'b1000);
        cmp_streams("R1 after empty line");

        // R9 set wins over a simultaneous clear
        clear_flags();
        send_line("@SIM2:2:FC2 2/2", 1);
        send_line("ACGT", 2);
        send_line("+", 0);
        send_byte("I");
        send_byte("I");
        exp_qual.push_back({1'b0, 8'h49});
        exp_qual.push_back({1'b1, 8'h49});
        send_byte(8'h0A, 1'b1);
        expect_flags("R9 set wins", 4'b0010);
        clear_flags();
        check(flags === 4'b0, "R9", "flags after clear", flags, 0);
        cmp_streams("R2 final");

        finish_run();
    end

endmodule